// File: doc/BRIEF.md
# SCSI Controller Command and Status Core

This block is the byte-wide register core of a SCSI bus controller. A host reaches sixteen byte registers through a simple register bus. The register index comes from address bits [5:2]. Writing the command register starts one of a fixed set of operations. Each operation loads the status, interrupt-reason and sequence-step registers with its own fixed codes, and may raise the single interrupt line.

The target side reports through three kinds of input. One is a presence vector for the targets. Another tells whether a data phase follows a command, and in which direction. The last is a one-cycle pulse that reports that a command has completed. The controller holds the destination target ID, written through register 4. A select command checks that ID against the presence vector. Software takes an interrupt by reading the interrupt-reason register. That read clears the transient status bits and drops the interrupt line.

Top module: `scsi_cmd_core`

## Requirements
- R1: After reset, register 14 reads 0x04, every other register reads 0x00, and `irq` and `irq_pulse` are low.
- R2: A write to register 0, 1, 3, 8, 12, 13, 14 or 15 reads back as written. A write to register 11 reads back as the data ANDed with 0x15. Writes to registers 2, 9 and 10 leave their read value unchanged. Writes to registers 4 to 7 do not change what those registers read. A write to register 4 stores its bits [2:0] as the destination target ID.
- R3: Command register bit 7 is the DMA flag and bits [6:0] are the opcode. Opcode 0x01 (flush) sets register 5 to 0x08 and register 6 to 0x00, and leaves `irq` unchanged.
- R4: Opcode 0x03 (bus reset) sets register 5 to 0x80. It raises `irq` only when bit 6 of register 8 is 0.
- R5: Opcode 0x42 or 0x43 with a destination ID of 4 or more, or naming an absent target, sets register 4 to 0x80, register 5 to 0x20 and register 6 to 0x00, and raises `irq`.
- R6: Opcode 0x42 to a present target sets register 5 to 0x18 and register 6 to 0x04, and raises `irq`. When `tgt_data_pend` is high, register 4 becomes 0x91 for data in and 0x90 for data out. When it is low, register 4 is unchanged.
- R7: Opcode 0x43 to a present target sets register 4 to 0x92, register 5 to 0x18 and register 6 to 0x04, and raises `irq`. The next opcode 0x10 then completes the held command exactly as in R6.
- R8: Opcode 0x10 with no held command sets register 5 to 0x10, and registers 6 and 7 to 0x00. It sets register 4 to 0x90 or 0x91 when `tgt_data_pend` is high, and raises `irq`.
- R9: Opcode 0x11 with DMA set sets register 4 to 0x93, register 5 to 0x18 and register 6 to 0x04. With DMA clear it sets register 7 to 0x02. Either way it raises `irq`. A `tgt_cmd_done` pulse sets register 4 to 0x93 without raising `irq`.
- R10: Opcode 0x12 sets register 5 to 0x20 and register 6 to 0x00, and raises `irq`. With DMA set it also sets register 4 to 0x93. With DMA clear it sets register 7 to 0x02.
- R11: A read of register 5 returns its value unchanged. It then leaves only bit 4 (terminal count) of register 4 and drives `irq` low.
- R12: Opcode 0x02 returns every register, the destination ID, any held command and `irq` to the reset state.
- R13: Opcode 0x00 and any opcode not listed above leave registers 4 to 7 and `irq` unchanged. Register 3 still records the written byte.
- R14: `irq_pulse` is high for exactly the one cycle after each write that raises `irq`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register bus address; bits [5:2] select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; takes effect only when bus_wr is low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| tgt_present | input | 4 | One bit per target: target present |
| tgt_data_pend | input | 1 | A data phase follows the current command |
| tgt_data_in | input | 1 | Data phase direction: 1 means in, 0 means out |
| tgt_cmd_done | input | 1 | One-cycle pulse: the target finished a command |
| irq | output | 1 | Interrupt line, level |
| irq_pulse | output | 1 | One-cycle pulse on each interrupt raise |

## Verification
The bench builds the block with its default parameters: four targets and sixteen registers. With this build the ID values 4 to 7 fall outside the target range, so the rejection path of R5 can be reached through the plain 3-bit ID field. The random presence vectors also reach that path for absent targets with an in-range ID. The random sequence also mixes rare opcodes into the command stream: chip reset, unknown codes, and a held select followed by transfer information. This brings ordering cases within reach, such as a bus reset arriving while the mask bit is set.

// File: rtl/scsi_core_pkg.sv
package scsi_core_pkg;

  localparam int IX_CMD  = 3;
  localparam int IX_DEST = 4;
  localparam int IX_STAT = 4;
  localparam int IX_INT  = 5;
  localparam int IX_SEQ  = 6;
  localparam int IX_CNT  = 7;
  localparam int IX_CFG  = 8;
  localparam int IX_CFG3 = 11;
  localparam int IX_ID   = 14;

  localparam logic [7:0] ID_VALUE  = 8'h04;
  localparam logic [7:0] CFG3_KEEP = 8'h15;
  localparam logic [7:0] TC_KEEP   = 8'h10;

  typedef enum logic [6:0] {
    OP_NOP      = 7'h00,
    OP_FLUSH    = 7'h01,
    OP_CHIP_RST = 7'h02,
    OP_BUS_RST  = 7'h03,
    OP_XFER     = 7'h10,
    OP_CMPL     = 7'h11,
    OP_MSG_ACC  = 7'h12,
    OP_SEL      = 7'h42,
    OP_SEL_STOP = 7'h43
  } opcode_e;

  typedef enum logic [2:0] {
    PH_DOUT = 3'd0, PH_DIN = 3'd1, PH_CMD = 3'd2,
    PH_STAT = 3'd3, PH_MIN = 3'd6, PH_MOUT = 3'd7
  } phase_e;

  typedef struct packed {
    logic       set_stat;
    logic [7:0] stat;
    logic       set_int;
    logic [7:0] intr;
    logic       set_seq;
    logic [7:0] seq;
    logic       set_cnt;
    logic [7:0] cnt;
    logic       raise;
    logic       chip_rst;
    logic       stop_set;
    logic       stop_clr;
  } upd_t;

  // Status byte: interrupt flag in bit 7, terminal count in bit 4, phase low
  function automatic logic [7:0] stat_enc(input logic irqf, input logic tc,
                                          input phase_e ph);
    return {irqf, 2'b00, tc, 1'b0, ph};
  endfunction

  // Bits a bus write may store, per register index
  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      0, 1, 3, 8, 12, 13, 14, 15: return 8'hFF;
      IX_CFG3:                    return CFG3_KEEP;
      default:                    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int idx);
    return (idx == IX_ID) ? ID_VALUE : 8'h00;
  endfunction

  function automatic logic op_is_known(input logic [6:0] op);
    case (op)
      OP_NOP, OP_FLUSH, OP_CHIP_RST, OP_BUS_RST, OP_XFER,
      OP_CMPL, OP_MSG_ACC, OP_SEL, OP_SEL_STOP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/scsi_reg_decode.sv
module scsi_reg_decode #(
  parameter int ADDR_W   = 6,
  parameter int ADDR_LSB = 2,
  parameter int REG_CNT  = 16,
  localparam int IDX_W   = $clog2(REG_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [IDX_W-1:0]    idx,
  output logic [REG_CNT-1:0]  wr_stb,
  output logic                cmd_wr,
  output logic                int_rd
);
  import scsi_core_pkg::*;

  logic unused_addr_lo;
  assign unused_addr_lo = ^{bus_addr[ADDR_LSB-1:0], bus_addr[ADDR_W-1:ADDR_LSB+IDX_W]};

  assign idx = bus_addr[ADDR_LSB +: IDX_W];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_stb
    assign wr_stb[g] = bus_wr && (idx == IDX_W'(g));
  end

  assign cmd_wr = bus_wr && (idx == IDX_W'(IX_CMD));
  assign int_rd = bus_rd && !bus_wr && (idx == IDX_W'(IX_INT));

  // R2
  wr_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

endmodule

// File: rtl/scsi_cmd_exec.sv
module scsi_cmd_exec (
  input  logic [6:0]          op,
  input  logic                dma,
  input  logic                tgt_ok,
  input  logic                data_pend,
  input  logic                data_in,
  input  logic                bus_rst_mask,
  input  logic                stop_pend,
  output scsi_core_pkg::upd_t u
);
  import scsi_core_pkg::*;

  logic [7:0] data_stat;
  assign data_stat = stat_enc(1'b1, 1'b1, data_in ? PH_DIN : PH_DOUT);

  always_comb begin
    u = '0;
    case (op)
      OP_FLUSH: begin
        u.set_int = 1'b1; u.intr = 8'h08;
        u.set_seq = 1'b1; u.seq  = 8'h00;
      end
      OP_CHIP_RST: u.chip_rst = 1'b1;
      OP_BUS_RST: begin
        u.set_int = 1'b1; u.intr = 8'h80;
        u.raise   = !bus_rst_mask;
      end
      OP_SEL, OP_SEL_STOP: begin
        u.raise   = 1'b1;
        u.set_seq = 1'b1;
        u.set_int = 1'b1;
        if (!tgt_ok) begin
          u.set_stat = 1'b1; u.stat = 8'h80;
          u.intr = 8'h20;    u.seq  = 8'h00;
        end else begin
          u.intr = 8'h18;    u.seq  = 8'h04;
          if (op == OP_SEL_STOP) begin
            u.set_stat = 1'b1; u.stat = stat_enc(1'b1, 1'b1, PH_CMD);
            u.stop_set = 1'b1;
          end else if (data_pend) begin
            u.set_stat = 1'b1; u.stat = data_stat;
          end
        end
      end
      OP_XFER: begin
        u.raise   = 1'b1;
        u.set_seq = 1'b1;
        u.set_int = 1'b1;
        if (stop_pend) begin
          u.stop_clr = 1'b1;
          u.intr = 8'h18; u.seq = 8'h04;
        end else begin
          u.intr = 8'h10; u.seq = 8'h00;
          u.set_cnt = 1'b1; u.cnt = 8'h00;
        end
        if (data_pend) begin
          u.set_stat = 1'b1; u.stat = data_stat;
        end
      end
      OP_CMPL, OP_MSG_ACC: begin
        u.raise = 1'b1;
        if (dma) begin
          u.set_stat = 1'b1; u.stat = stat_enc(1'b1, 1'b1, PH_STAT);
        end else begin
          u.set_cnt = 1'b1; u.cnt = 8'h02;
        end
        u.set_int = 1'b1;
        u.set_seq = 1'b1;
        if (op == OP_MSG_ACC) begin
          u.intr = 8'h20; u.seq = 8'h00;
        end else begin
          u.set_int = dma; u.intr = 8'h18;
          u.set_seq = dma; u.seq  = 8'h04;
        end
      end
      default: u = '0;
    endcase
  end

endmodule

// File: rtl/scsi_irq_ctrl.sv
module scsi_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic chip_rst,
  output logic irq,
  output logic irq_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= raise && !chip_rst;
      if (chip_rst)   irq <= 1'b0;
      else if (raise) irq <= 1'b1;
      else if (clear) irq <= 1'b0;
    end
  end

  // R14
  pulse_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq);

  // R14
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raise |=> !irq_pulse);

  // R11
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !raise) |=> !irq);

endmodule

// File: rtl/scsi_cmd_core.sv
module scsi_cmd_core #(
  parameter int ADDR_W   = 6,
  parameter int ADDR_LSB = 2,
  parameter int REG_CNT  = 16,
  parameter int NUM_TGT  = 4,
  localparam int IDX_W   = $clog2(REG_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_TGT-1:0] tgt_present,
  input  logic               tgt_data_pend,
  input  logic               tgt_data_in,
  input  logic               tgt_cmd_done,
  output logic               irq,
  output logic               irq_pulse
);
  import scsi_core_pkg::*;

  logic [7:0]         rf [REG_CNT];
  logic [2:0]         dest_id;
  logic               stop_pend;
  logic [IDX_W-1:0]   idx;
  logic [REG_CNT-1:0] wr_stb;
  logic               cmd_wr, int_rd;
  logic [7:0]         pres_pad;
  logic               tgt_ok;
  upd_t               upd;
  logic               do_raise, do_chip_rst;
  logic [7:0]         stat_q, int_q, seq_q, cfg_q, cfg3_q;

  scsi_reg_decode #(.ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB), .REG_CNT(REG_CNT)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .idx(idx), .wr_stb(wr_stb), .cmd_wr(cmd_wr), .int_rd(int_rd)
  );

  always_comb begin
    pres_pad = '0;
    pres_pad[NUM_TGT-1:0] = tgt_present;
  end
  assign tgt_ok = (int'(dest_id) < NUM_TGT) && pres_pad[dest_id];

  assign cfg_q  = rf[IX_CFG];
  assign stat_q = rf[IX_STAT];
  assign int_q  = rf[IX_INT];
  assign seq_q  = rf[IX_SEQ];
  assign cfg3_q = rf[IX_CFG3];

  scsi_cmd_exec u_exec (
    .op(bus_wdata[6:0]), .dma(bus_wdata[7]), .tgt_ok(tgt_ok),
    .data_pend(tgt_data_pend), .data_in(tgt_data_in),
    .bus_rst_mask(cfg_q[6]), .stop_pend(stop_pend), .u(upd)
  );

  assign do_raise    = cmd_wr && upd.raise;
  assign do_chip_rst = cmd_wr && upd.chip_rst;

  scsi_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .raise(do_raise), .clear(int_rd),
    .chip_rst(do_chip_rst), .irq(irq), .irq_pulse(irq_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= rst_val(i);
      dest_id   <= '0;
      stop_pend <= 1'b0;
    end else if (do_chip_rst) begin
      for (int i = 0; i < REG_CNT; i++) rf[i] <= rst_val(i);
      dest_id   <= '0;
      stop_pend <= 1'b0;
    end else begin
      for (int i = 0; i < REG_CNT; i++)
        if (wr_stb[i] && (wr_mask(i) != 8'h00)) rf[i] <= bus_wdata & wr_mask(i);
      if (wr_stb[IX_DEST]) dest_id <= bus_wdata[2:0];
      if (cmd_wr) begin
        if (upd.set_int) rf[IX_INT] <= upd.intr;
        if (upd.set_seq) rf[IX_SEQ] <= upd.seq;
        if (upd.set_cnt) rf[IX_CNT] <= upd.cnt;
        if (upd.stop_set)      stop_pend <= 1'b1;
        else if (upd.stop_clr) stop_pend <= 1'b0;
      end
      if (tgt_cmd_done)
        rf[IX_STAT] <= stat_enc(1'b1, 1'b1, PH_STAT);
      else if (cmd_wr && upd.set_stat)
        rf[IX_STAT] <= upd.stat;
      else if (int_rd)
        rf[IX_STAT] <= rf[IX_STAT] & TC_KEEP;
    end
  end

  assign bus_rdata = rf[idx];

  // R11
  int_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd && !tgt_cmd_done) |=> ((stat_q & ~TC_KEEP) == 8'h00) && !irq && $stable(int_q));

  // R2
  cfg3_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[IX_CFG3] |=> ((cfg3_q & ~CFG3_KEEP) == 8'h00));

  // R4
  bus_rst_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[6:0] == OP_BUS_RST && cfg_q[6]) |=> (!irq_pulse && int_q == 8'h80));

  // R5
  bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (bus_wdata[6:0] == OP_SEL || bus_wdata[6:0] == OP_SEL_STOP)
     && !tgt_ok && !tgt_cmd_done)
    |=> (stat_q == 8'h80 && int_q == 8'h20 && seq_q == 8'h00 && irq));

  // R13
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !op_is_known(bus_wdata[6:0]) && !tgt_cmd_done)
    |=> ($stable(stat_q) && $stable(int_q) && $stable(seq_q) && $stable(irq)));

  // R12
  chip_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_chip_rst |=> (!irq && stat_q == 8'h00 && rf[IX_ID] == ID_VALUE));

endmodule

// File: tb/tb_scsi_cmd_core.sv
`timescale 1ns/1ps
module tb_scsi_cmd_core;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NT-1:0] tgt_present = '0;
  logic          tgt_data_pend = 1'b0, tgt_data_in = 1'b0, tgt_cmd_done = 1'b0;
  logic          irq, irq_pulse;

  scsi_cmd_core #(.NUM_TGT(NT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_present(tgt_present),
    .tgt_data_pend(tgt_data_pend), .tgt_data_in(tgt_data_in),
    .tgt_cmd_done(tgt_cmd_done), .irq(irq), .irq_pulse(irq_pulse)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] m [16];
  logic       m_irq, m_pulse, m_stop;
  logic [2:0] m_dest;

  function automatic logic [7:0] x_mask(int i);
    if (i == 11) return 8'h15;
    if (i == 0 || i == 1 || i == 3 || i == 8 || i >= 12) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m[i] = (i == 14) ? 8'h04 : 8'h00;
    m_irq = 0; m_pulse = 0; m_stop = 0; m_dest = 0;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_cmd(logic [7:0] d);
    logic ok, dma;
    logic [7:0] dstat;
    ok  = (m_dest < NT) && tgt_present[m_dest[1:0]];
    dma = d[7];
    dstat = tgt_data_in ? 8'h91 : 8'h90;
    case (d[6:0])
      7'h01: begin m[5] = 8'h08; m[6] = 8'h00; end
      7'h02: m_reset();
      7'h03: begin m[5] = 8'h80; if (!m[8][6]) m_pulse = 1; end
      7'h42, 7'h43: begin
        m_pulse = 1;
        if (!ok) begin m[4] = 8'h80; m[5] = 8'h20; m[6] = 8'h00; end
        else begin
          m[5] = 8'h18; m[6] = 8'h04;
          if (d[6:0] == 7'h43) begin m[4] = 8'h92; m_stop = 1; end
          else if (tgt_data_pend) m[4] = dstat;
        end
      end
      7'h10: begin
        m_pulse = 1;
        if (m_stop) begin m_stop = 0; m[5] = 8'h18; m[6] = 8'h04; end
        else begin m[5] = 8'h10; m[6] = 8'h00; m[7] = 8'h00; end
        if (tgt_data_pend) m[4] = dstat;
      end
      7'h11: begin
        m_pulse = 1;
        if (dma) begin m[4] = 8'h93; m[5] = 8'h18; m[6] = 8'h04; end
        else m[7] = 8'h02;
      end
      7'h12: begin
        m_pulse = 1;
        if (dma) m[4] = 8'h93; else m[7] = 8'h02;
        m[5] = 8'h20; m[6] = 8'h00;
      end
      default: ;
    endcase
    if (m_pulse) m_irq = 1;
  endtask

  task automatic do_wr(int i, logic [7:0] d);
    @(negedge clk);
    bus_addr = 6'(i << 2); bus_wdata = d; bus_wr = 1;
    m_pulse = 0;
    if (x_mask(i) != 0) m[i] = d & x_mask(i);
    if (i == 4) m_dest = d[2:0];
    if (i == 3) m_cmd(d);
    @(negedge clk);
    bus_wr = 0;
    chk("R14 pulse", {7'b0, irq_pulse}, {7'b0, m_pulse});
    chk("R14 irq", {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic do_rd(int i, string req, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 6'(i << 2); bus_rd = 1;
    #1 v = bus_rdata;
    chk(req, v, m[i]);
    if (i == 5) begin m[4] = m[4] & 8'h10; m_irq = 0; end
    @(negedge clk);
    bus_rd = 0;
    chk("R11 irq", {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic done_pulse();
    @(negedge clk);
    tgt_cmd_done = 1; m[4] = 8'h93;
    @(negedge clk);
    tgt_cmd_done = 0;
  endtask

  initial begin
    #(8.0 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ops [11];
    ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h42, 8'h43, 8'h1a, 8'h55};
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 16; i++) do_rd(i, "R1", v);
    do_rd(14, "R1", v); chk("R1 id", v, 8'h04);
    // R2 write masking
    do_wr(11, 8'hFF); do_rd(11, "R2", v); chk("R2 mask", v, 8'h15);
    do_wr(12, 8'h5A); do_rd(12, "R2", v); chk("R2 store", v, 8'h5A);
    do_wr(9, 8'h77);  do_rd(9, "R2", v);  chk("R2 ignore", v, 8'h00);
    do_wr(6, 8'h33);  do_rd(6, "R2", v);  chk("R2 ro", v, 8'h00);
    // R3 flush
    do_wr(3, 8'h01); do_rd(5, "R3", v); chk("R3 int", v, 8'h08);
    chk("R3 irq", {7'b0, irq}, 8'h00);
    // R4 bus reset unmasked then masked
    do_wr(3, 8'h03); chk("R4 irq", {7'b0, irq}, 8'h01);
    do_rd(5, "R11", v); chk("R4 int", v, 8'h80);
    do_wr(8, 8'h40); do_wr(3, 8'h03); chk("R4 masked", {7'b0, irq}, 8'h00);
    do_wr(8, 8'h00);
    // R5 out-of-range and absent
    tgt_present = 4'b0010;
    do_wr(4, 8'h05); do_wr(3, 8'h42); do_rd(4, "R5", v); chk("R5 stat", v, 8'h80);
    do_rd(5, "R5", v); chk("R5 int", v, 8'h20);
    do_wr(4, 8'h02); do_wr(3, 8'hC3); do_rd(4, "R5", v); chk("R5 absent", v, 8'h80);
    // R6 accepted with data in
    tgt_data_pend = 1; tgt_data_in = 1;
    do_wr(4, 8'h01); do_wr(3, 8'h42); do_rd(4, "R6", v); chk("R6 stat", v, 8'h91);
    do_rd(6, "R6", v); chk("R6 seq", v, 8'h04);
    do_rd(5, "R6", v); chk("R6 int", v, 8'h18);
    do_rd(4, "R11", v); chk("R11 keep tc", v, 8'h10);
    // R7 select-stop then transfer, data out
    tgt_data_in = 0;
    do_wr(3, 8'h43); do_rd(4, "R7", v); chk("R7 stat", v, 8'h92);
    do_wr(3, 8'h10); do_rd(4, "R7", v); chk("R7 xfer", v, 8'h90);
    do_rd(5, "R7", v); chk("R7 int", v, 8'h18);
    // R8 plain transfer
    do_wr(3, 8'h10); do_rd(5, "R8", v); chk("R8 int", v, 8'h10);
    // R9 complete sequence and done pulse
    do_wr(3, 8'h91); do_rd(4, "R9", v); chk("R9 stat", v, 8'h93);
    do_wr(3, 8'h11); do_rd(7, "R9", v); chk("R9 cnt", v, 8'h02);
    do_rd(5, "R9", v);
    done_pulse(); chk("R9 done irq", {7'b0, irq}, 8'h00);
    do_rd(4, "R9", v); chk("R9 done", v, 8'h93);
    // R10 message accepted
    do_wr(3, 8'h92); do_rd(5, "R10", v); chk("R10 int", v, 8'h20);
    // R13 unknown opcode
    do_wr(3, 8'h1a); do_rd(3, "R13", v); chk("R13 cmd", v, 8'h1a);
    do_rd(5, "R13", v); chk("R13 int", v, 8'h20);
    // R12 chip reset
    do_wr(3, 8'h03); do_wr(3, 8'h02);
    chk("R12 irq", {7'b0, irq}, 8'h00);
    do_rd(12, "R12", v); chk("R12 reg", v, 8'h00);
    do_rd(14, "R12", v); chk("R12 id", v, 8'h04);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      tgt_present   = NT'($urandom);
      tgt_data_pend = 1'($urandom);
      tgt_data_in   = 1'($urandom);
      if (r < 45) do_rd($urandom_range(0, 15), "R2 rand", v);
      else if (r < 80) do_wr(3, {1'($urandom), ops[$urandom_range(0, 10)][6:0]});
      else if (r < 88) do_wr(4, 8'($urandom));
      else if (r < 92) do_wr(8, 8'($urandom) & 8'h40);
      else if (r < 97) begin
        int i;
        i = $urandom_range(0, 15);
        if (i == 3) i = 13;
        do_wr(i, 8'($urandom));
      end
      else done_pulse();
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule